// File: doc/BRIEF.md
# Subaddress Receive Buffer Manager

This block sits between the word-level protocol engine of a bus terminal and the host. The engine marks the start of a received message, hands over its data words one at a time and then marks its end. At the start it says whether the message is for the periodic subaddress or for the queued subaddress. It may abandon a message at any point. The block stores every message that completes, together with a time tag taken from a free-running wrapping counter at the moment the message starts.

The periodic subaddress is double-buffered. Words are written into the hidden bank, and the banks change roles only when the message completes. The host's view is therefore always one whole message, and always the latest complete one. The queued subaddress feeds a ring of whole messages. The host drains the ring through a valid/ready stream. The engine side cannot be stalled, because a terminal has to meet its response window, so it has no ready signal. When the ring is full, one of three overflow policies decides what happens: drop the new message, drop the oldest message, or freeze. Every overflow is reported through a sticky flag and a counter.

Back-pressure rules on the host stream:
- The front message is offered while `q_valid` is high.
- A message is taken in a cycle where both `q_valid` and `q_ready` are high.
- While the host withholds `q_ready`, the offered message stays unchanged. The one exception is a drop-old overflow, which replaces it.

Top module: `sabuf_mgr`

## Requirements
- R1: After reset `p_valid`, `q_valid`, `ovf_flag`, `tag_wrap` and `ovf_cnt` are all 0.
- R2: A periodic message ends when `wr_end` is sampled, and the block then shows it from the following cycle. `p_data` word k is at bits [k*DATA_W +: DATA_W]. `p_len` gives the number of words stored, and data words at or beyond `p_len` read as zero. `p_tag` is the time tag of the message, and `p_valid` becomes 1.
- R3: While a periodic message is being written, `p_data`, `p_len` and `p_tag` keep the last complete message.
- R4: A message is discarded if `wr_abort` is sampled while it is open, or if a new `wr_start` is sampled while it is open. A discarded message changes neither the periodic view nor the ring. `wr_abort` takes priority over `wr_start`, `wr_start` over `wr_end`, and `wr_end` over `wr_valid`. A word presented in a cycle that also carries one of these strobes is not stored.
- R5: Queued messages leave in arrival order. A message is popped when `q_valid && q_ready`. While `q_valid && !q_ready`, the offered message holds steady unless a drop-old overflow happens.
- R6: With `ovf_mode` = 0 (drop-new), a queued message that completes while the ring holds `RING_DEPTH` messages is discarded, and the ring is left unchanged. A pop in the same cycle frees a place, so the message is stored and no overflow occurs.
- R7: With `ovf_mode` = 1 (drop-old), a message that completes into a full ring is stored, and the oldest message is removed.
- R8: With `ovf_mode` = 2 (freeze), a message that completes into a full ring is discarded, and the ring freezes. While frozen, every queued message that completes is rejected and counted as an overflow, while host pops continue to work. A pulse on `ovf_ack` lifts the freeze. Mode 3 behaves as mode 0.
- R9: Every overflow sets `ovf_flag` and increments `ovf_cnt`, which saturates at its maximum. A pulse on `ovf_ack` clears the flag but leaves the counter as it is. An overflow in the same cycle as `ovf_ack` leaves the flag set.
- R10: The time tag counts clock cycles since reset modulo 2^TAG_W. A message takes the counter value of the cycle in which its `wr_start` is sampled. `tag_wrap` is high for exactly one cycle, in the first cycle in which the counter reads zero again after rolling over.
- R11: Words beyond `MSG_WORDS` in one message are not stored, and the length stops at `MSG_WORDS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_mode | input | 2 | Overflow policy: 0 drop-new, 1 drop-old, 2 freeze |
| wr_start | input | 1 | Opens a message |
| wr_queued | input | 1 | With `wr_start`: 1 queued subaddress, 0 periodic |
| wr_valid | input | 1 | Data word present |
| wr_data | input | DATA_W | Data word |
| wr_end | input | 1 | Completes the open message |
| wr_abort | input | 1 | Discards the open message |
| p_valid | output | 1 | A periodic message has been completed |
| p_data | output | MSG_WORDS*DATA_W | Latest complete periodic message |
| p_len | output | $clog2(MSG_WORDS+1) | Its word count |
| p_tag | output | TAG_W | Its time tag |
| q_valid | output | 1 | The ring offers a message |
| q_ready | input | 1 | Host takes the offered message |
| q_data | output | MSG_WORDS*DATA_W | Front message data |
| q_len | output | $clog2(MSG_WORDS+1) | Front message word count |
| q_tag | output | TAG_W | Front message time tag |
| ovf_ack | input | 1 | Clears the overflow flag and the freeze |
| ovf_flag | output | 1 | Sticky overflow indication |
| ovf_cnt | output | CNT_W | Saturating overflow count |
| tag_wrap | output | 1 | One-cycle pulse on time tag rollover |

## Verification
The properties assume the engine's strobes are meaningful only inside a message. They also assume `ovf_mode` is held steady while a message is queued up against a full ring. The stimulus therefore keeps the mode constant for each phase and changes it only while the ring is empty and idle.

The stalled-stream property excludes cycles that carry `wr_end`, because a drop-old overflow may legally replace the front message. The stimulus keeps `q_ready` low while it fills the ring and writes nothing while it drains. As a result, every overflow decision and every pop happens in a cycle whose expected outcome is unambiguous.

// File: rtl/sabuf_pkg.sv
package sabuf_pkg;
  typedef enum logic [1:0] {
    OVF_DROP_NEW = 2'd0,
    OVF_DROP_OLD = 2'd1,
    OVF_FREEZE   = 2'd2,
    OVF_RSVD     = 2'd3
  } ovf_mode_e;

  typedef enum logic [1:0] {
    ASM_IDLE = 2'd0,
    ASM_PER  = 2'd1,
    ASM_QUE  = 2'd2
  } asm_state_e;
endpackage

// File: rtl/sabuf_asm.sv
module sabuf_asm
  import sabuf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MSG_WORDS = 4,
  parameter int TAG_W     = 8,
  localparam int LW       = $clog2(MSG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_queued,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_end,
  input  logic              wr_abort,
  input  logic [TAG_W-1:0]  tag_now,
  output logic              w_en,
  output logic              w_que,
  output logic [LW-1:0]     w_idx,
  output logic [DATA_W-1:0] w_data,
  output logic              open_p,
  output logic              open_q,
  output logic              close_p,
  output logic              close_q,
  output logic [LW-1:0]     msg_len,
  output logic [TAG_W-1:0]  msg_tag
);
  asm_state_e       st;
  logic [LW-1:0]    cnt;
  logic [TAG_W-1:0] tag_q;
  logic             take;
  logic             room;

  // a strobe in the same cycle masks the data word
  assign take = wr_valid && !wr_abort && !wr_start && !wr_end && (st != ASM_IDLE);
  assign room = (cnt < LW'(MSG_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ASM_IDLE;
      cnt   <= '0;
      tag_q <= '0;
    end else if (wr_abort) begin
      st <= ASM_IDLE;
    end else if (wr_start) begin
      st    <= wr_queued ? ASM_QUE : ASM_PER;
      cnt   <= '0;
      tag_q <= tag_now;
    end else if (wr_end) begin
      st <= ASM_IDLE;
    end else if (take && room) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign w_en    = take && room;
  assign w_que   = (st == ASM_QUE);
  assign w_idx   = cnt;
  assign w_data  = wr_data;
  assign open_p  = wr_start && !wr_abort && !wr_queued;
  assign open_q  = wr_start && !wr_abort && wr_queued;
  assign close_p = wr_end && !wr_abort && !wr_start && (st == ASM_PER);
  assign close_q = wr_end && !wr_abort && !wr_start && (st == ASM_QUE);
  assign msg_len = cnt;
  assign msg_tag = tag_q;
endmodule

// File: rtl/sabuf_dbuf.sv
module sabuf_dbuf #(
  parameter int DATA_W    = 16,
  parameter int MSG_WORDS = 4,
  parameter int TAG_W     = 8,
  localparam int MW       = MSG_WORDS * DATA_W,
  localparam int LW       = $clog2(MSG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              w_en,
  input  logic [LW-1:0]     w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              close,
  input  logic [LW-1:0]     msg_len,
  input  logic [TAG_W-1:0]  msg_tag,
  output logic              p_valid,
  output logic [MW-1:0]     p_data,
  output logic [LW-1:0]     p_len,
  output logic [TAG_W-1:0]  p_tag
);
  logic [MW-1:0]    bank_d [2];
  logic [LW-1:0]    bank_l [2];
  logic [TAG_W-1:0] bank_t [2];
  logic             shown;
  logic             hidden;
  logic             have;

  assign hidden = ~shown;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        bank_d[b] <= '0;
        bank_l[b] <= '0;
        bank_t[b] <= '0;
      end
      shown <= 1'b0;
      have  <= 1'b0;
    end else begin
      // all writing goes to the hidden bank; the host sees only the other
      if (open) bank_d[hidden] <= '0;
      else if (w_en) bank_d[hidden][w_idx*DATA_W +: DATA_W] <= w_data;
      if (close) begin
        bank_l[hidden] <= msg_len;
        bank_t[hidden] <= msg_tag;
        shown          <= hidden;
        have           <= 1'b1;
      end
    end
  end

  assign p_valid = have;
  assign p_data  = bank_d[shown];
  assign p_len   = bank_l[shown];
  assign p_tag   = bank_t[shown];
endmodule

// File: rtl/sabuf_ring.sv
module sabuf_ring
  import sabuf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MSG_WORDS  = 4,
  parameter int TAG_W      = 8,
  parameter int RING_DEPTH = 4,
  localparam int MW        = MSG_WORDS * DATA_W,
  localparam int LW        = $clog2(MSG_WORDS + 1),
  localparam int PW        = $clog2(RING_DEPTH),
  localparam int CW        = $clog2(RING_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ovf_mode_e         mode,
  input  logic              open,
  input  logic              w_en,
  input  logic [LW-1:0]     w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              close,
  input  logic [LW-1:0]     msg_len,
  input  logic [TAG_W-1:0]  msg_tag,
  input  logic              ovf_ack,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [MW-1:0]     q_data,
  output logic [LW-1:0]     q_len,
  output logic [TAG_W-1:0]  q_tag,
  output logic              ovf_evt,
  output logic [CW-1:0]     q_count,
  output logic              q_frozen
);
  logic [MW-1:0]    stg;
  logic [MW-1:0]    mem_d [RING_DEPTH];
  logic [LW-1:0]    mem_l [RING_DEPTH];
  logic [TAG_W-1:0] mem_t [RING_DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    count;
  logic             frozen;
  logic             pop, full, do_write, drop_front, set_frz, grow;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(RING_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop  = q_valid && q_ready;
  assign full = (count == CW'(RING_DEPTH));

  always_comb begin
    do_write   = 1'b0;
    drop_front = 1'b0;
    set_frz    = 1'b0;
    ovf_evt    = 1'b0;
    if (close) begin
      if (frozen) begin
        ovf_evt = 1'b1;
      end else if (full && !pop) begin
        ovf_evt = 1'b1;
        case (mode)
          OVF_DROP_OLD: begin do_write = 1'b1; drop_front = 1'b1; end
          OVF_FREEZE:   set_frz = 1'b1;
          default:      ;
        endcase
      end else begin
        do_write = 1'b1;
      end
    end
  end

  assign grow = do_write && !drop_front;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg    <= '0;
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      frozen <= 1'b0;
      for (int i = 0; i < RING_DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_l[i] <= '0;
        mem_t[i] <= '0;
      end
    end else begin
      if (open) stg <= '0;
      else if (w_en) stg[w_idx*DATA_W +: DATA_W] <= w_data;
      if (do_write) begin
        mem_d[wp] <= stg;
        mem_l[wp] <= msg_len;
        mem_t[wp] <= msg_tag;
        wp        <= nxt(wp);
      end
      if (pop || drop_front) rp <= nxt(rp);
      if (grow && !pop) count <= count + 1'b1;
      else if (pop && !grow) count <= count - 1'b1;
      if (set_frz) frozen <= 1'b1;
      else if (ovf_ack) frozen <= 1'b0;
    end
  end

  assign q_valid  = (count != '0);
  assign q_data   = mem_d[rp];
  assign q_len    = mem_l[rp];
  assign q_tag    = mem_t[rp];
  assign q_count  = count;
  assign q_frozen = frozen;
endmodule

// File: rtl/sabuf_mgr.sv
module sabuf_mgr
  import sabuf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MSG_WORDS  = 4,
  parameter int RING_DEPTH = 4,
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 8,
  localparam int MW        = MSG_WORDS * DATA_W,
  localparam int LW        = $clog2(MSG_WORDS + 1),
  localparam int QCW       = $clog2(RING_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ovf_mode,
  input  logic              wr_start,
  input  logic              wr_queued,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_end,
  input  logic              wr_abort,
  output logic              p_valid,
  output logic [MW-1:0]     p_data,
  output logic [LW-1:0]     p_len,
  output logic [TAG_W-1:0]  p_tag,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [MW-1:0]     q_data,
  output logic [LW-1:0]     q_len,
  output logic [TAG_W-1:0]  q_tag,
  input  logic              ovf_ack,
  output logic              ovf_flag,
  output logic [CNT_W-1:0]  ovf_cnt,
  output logic              tag_wrap
);
  logic [TAG_W-1:0]  tcnt;
  logic              w_en, w_que, open_p, open_q, close_p, close_q;
  logic [LW-1:0]     w_idx, msg_len;
  logic [DATA_W-1:0] w_data;
  logic [TAG_W-1:0]  msg_tag;
  logic              ovf_evt;
  logic [QCW-1:0]    q_count;
  logic              q_frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      tag_wrap <= 1'b0;
    end else begin
      tcnt     <= tcnt + 1'b1;
      tag_wrap <= &tcnt;
    end
  end

  sabuf_asm #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS), .TAG_W(TAG_W)) u_asm (
    .clk, .rst_n, .wr_start, .wr_queued, .wr_valid, .wr_data, .wr_end, .wr_abort,
    .tag_now(tcnt), .w_en, .w_que, .w_idx, .w_data, .open_p, .open_q,
    .close_p, .close_q, .msg_len, .msg_tag
  );

  sabuf_dbuf #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS), .TAG_W(TAG_W)) u_dbuf (
    .clk, .rst_n, .open(open_p), .w_en(w_en && !w_que), .w_idx, .w_data,
    .close(close_p), .msg_len, .msg_tag, .p_valid, .p_data, .p_len, .p_tag
  );

  sabuf_ring #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS), .TAG_W(TAG_W),
               .RING_DEPTH(RING_DEPTH)) u_ring (
    .clk, .rst_n, .mode(ovf_mode_e'(ovf_mode)), .open(open_q), .w_en(w_en && w_que),
    .w_idx, .w_data, .close(close_q), .msg_len, .msg_tag, .ovf_ack,
    .q_valid, .q_ready, .q_data, .q_len, .q_tag, .ovf_evt, .q_count, .q_frozen
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      ovf_cnt  <= '0;
    end else begin
      if (ovf_evt) ovf_flag <= 1'b1;
      else if (ovf_ack) ovf_flag <= 1'b0;
      if (ovf_evt && !(&ovf_cnt)) ovf_cnt <= ovf_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sabuf_chk.sv
module sabuf_chk #(
  parameter int MW    = 64,
  parameter int TAG_W = 8,
  parameter int CNT_W = 8,
  parameter int QCW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_end,
  input logic [MW-1:0]    p_data,
  input logic [TAG_W-1:0] p_tag,
  input logic             q_valid,
  input logic             q_ready,
  input logic [MW-1:0]    q_data,
  input logic             ovf_ack,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] ovf_cnt,
  input logic             tag_wrap,
  input logic [QCW-1:0]   q_count,
  input logic             q_frozen
);
  // R3
  per_view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_end |=> ($stable(p_data) && $stable(p_tag)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready && !wr_end) |=> (q_valid && $stable(q_data)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_ack) |=> ovf_flag);

  // R9
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_cnt >= $past(ovf_cnt));

  // R8
  frozen_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_frozen && !q_ready) |=> (q_count == $past(q_count)));

  // R10
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wrap |=> !tag_wrap);
endmodule

bind sabuf_mgr sabuf_chk #(.MW(MW), .TAG_W(TAG_W), .CNT_W(CNT_W), .QCW(QCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .p_data(p_data), .p_tag(p_tag),
  .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .ovf_ack(ovf_ack),
  .ovf_flag(ovf_flag), .ovf_cnt(ovf_cnt), .tag_wrap(tag_wrap),
  .q_count(q_count), .q_frozen(q_frozen)
);

// File: tb/tb_sabuf_mgr.sv
`timescale 1ns/1ps
module tb_sabuf_mgr;
  localparam int DW = 16, NW = 4, DEPTH = 4, TW = 8, CW = 8;
  localparam int MW = DW * NW, LW = $clog2(NW + 1);

  logic clk = 0, rst_n = 0;
  logic [1:0] ovf_mode = 0;
  logic wr_start = 0, wr_queued = 0, wr_valid = 0, wr_end = 0, wr_abort = 0;
  logic [DW-1:0] wr_data = 0;
  logic p_valid, q_valid, q_ready = 0, ovf_ack = 0, ovf_flag, tag_wrap;
  logic [MW-1:0] p_data, q_data;
  logic [LW-1:0] p_len, q_len;
  logic [TW-1:0] p_tag, q_tag;
  logic [CW-1:0] ovf_cnt;

  sabuf_mgr #(.DATA_W(DW), .MSG_WORDS(NW), .RING_DEPTH(DEPTH), .TAG_W(TW), .CNT_W(CW)) dut (
    .clk, .rst_n, .ovf_mode, .wr_start, .wr_queued, .wr_valid, .wr_data, .wr_end, .wr_abort,
    .p_valid, .p_data, .p_len, .p_tag, .q_valid, .q_ready, .q_data, .q_len, .q_tag,
    .ovf_ack, .ovf_flag, .ovf_cnt, .tag_wrap
  );

  always #2.5 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, ovfn = 0;
  bit done = 0, frz = 0, eflag = 0;
  logic [MW-1:0] eq_d [$];
  logic [LW-1:0] eq_l [$];
  logic [TW-1:0] eq_t [$];
  logic [MW-1:0] pd = 0;
  logic [LW-1:0] pl = 0;
  logic [TW-1:0] pt = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of the queue and the overflow reporting
  task automatic model_push(input logic [MW-1:0] d, input logic [LW-1:0] l, input logic [TW-1:0] t, input bit ack);
    bit ov = 0;
    if (frz) ov = 1;
    else if (eq_d.size() == DEPTH) begin
      ov = 1;
      if (ovf_mode == 2'd1) begin
        void'(eq_d.pop_front()); void'(eq_l.pop_front()); void'(eq_t.pop_front());
        eq_d.push_back(d); eq_l.push_back(l); eq_t.push_back(t);
      end else if (ovf_mode == 2'd2) frz = 1;
    end else begin
      eq_d.push_back(d); eq_l.push_back(l); eq_t.push_back(t);
    end
    if (ov) begin ovfn++; eflag = 1; end
    else if (ack) begin eflag = 0; frz = 0; end
  endtask

  task automatic send(input bit que, input int n, input logic [DW-1:0] base, input bit abort, input bit ack_end);
    logic [MW-1:0] d = 0;
    logic [LW-1:0] l = 0;
    logic [TW-1:0] t;
    @(negedge clk);
    wr_start = 1; wr_queued = que; t = cyc[TW-1:0];
    @(negedge clk);
    wr_start = 0;
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = base + DW'(i);
      if (i < NW) begin d[i*DW +: DW] = base + DW'(i); l++; end
      @(negedge clk);
    end
    wr_valid = 0;
    #1;
    if (!que) chk(p_data === pd && p_tag === pt, "R3 view held mid-message", 64'(p_data), 64'(pd));
    if (abort) wr_abort = 1;
    else begin wr_end = 1; ovf_ack = ack_end; end
    @(negedge clk);
    wr_abort = 0; wr_end = 0; ovf_ack = 0;
    if (!abort) begin
      if (que) model_push(d, l, t, ack_end);
      else begin pd = d; pl = l; pt = t; end
    end
    #1;
  endtask

  task automatic chk_per(input string req);
    chk(p_valid === 1'b1, req, 64'(p_valid), 64'd1);
    chk(p_data === pd, req, 64'(p_data), 64'(pd));
    chk(p_len === pl, req, 64'(p_len), 64'(pl));
    chk(p_tag === pt, req, 64'(p_tag), 64'(pt));
  endtask

  task automatic chk_ovf(input string req);
    chk(ovf_flag === eflag, req, 64'(ovf_flag), 64'(eflag));
    chk(ovf_cnt === CW'(ovfn), req, 64'(ovf_cnt), 64'(ovfn));
  endtask

  task automatic ack_pulse();
    @(negedge clk); ovf_ack = 1;
    @(negedge clk); ovf_ack = 0;
    eflag = 0; frz = 0;
    #1;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    @(negedge clk); q_ready = 1;
    while (eq_d.size() != 0 && guard < 100) begin @(negedge clk); guard++; end
    q_ready = 0;
    #1;
    chk(q_valid === 1'b0 && eq_d.size() == 0, req, 64'(q_valid), 64'd0);
  endtask

  // scoreboard monitor: compares every popped message with the model
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && q_valid && q_ready) begin
        if (eq_d.size() == 0) chk(0, "R5 unexpected pop", 64'(q_data), 64'd0);
        else begin
          chk(q_data === eq_d[0], "R5 queue data order", 64'(q_data), 64'(eq_d[0]));
          chk(q_len === eq_l[0] && q_tag === eq_t[0], "R5 queue len/tag", 64'({q_len, q_tag}), 64'({eq_l[0], eq_t[0]}));
          void'(eq_d.pop_front()); void'(eq_l.pop_front()); void'(eq_t.pop_front());
        end
      end
      if (rst_n && cyc >= 256 && cyc[TW-1:0] <= 1)
        chk(tag_wrap === (cyc[TW-1:0] == 0), "R10 wrap pulse", 64'(tag_wrap), 64'(cyc[TW-1:0] == 0));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(p_valid === 0 && q_valid === 0 && ovf_flag === 0 && tag_wrap === 0, "R1 reset outputs",
        64'({p_valid, q_valid, ovf_flag, tag_wrap}), 64'd0);
    chk(ovf_cnt === 0, "R1 reset count", 64'(ovf_cnt), 64'd0);
    @(negedge clk); rst_n = 1;

    send(0, 3, 16'h1000, 0, 0); chk_per("R2 periodic message shown");
    chk(p_data[3*DW +: DW] === 0, "R2 unused word zero", 64'(p_data[3*DW +: DW]), 64'd0);
    send(0, 2, 16'h2000, 0, 0); chk_per("R2 second periodic message");
    send(0, 4, 16'h3000, 1, 0); chk_per("R4 periodic abort ignored");
    send(1, 2, 16'h3100, 1, 0);
    chk(q_valid === 0, "R4 queued abort ignored", 64'(q_valid), 64'd0);
    send(0, 6, 16'h4000, 0, 0); chk_per("R11 oversize truncated");

    // drop-new
    ovf_mode = 2'd0;
    for (int m = 0; m < DEPTH; m++) send(1, m + 1, 16'h5000 + 16'(m * 16), 0, 0);
    @(negedge clk); #1;
    chk(q_valid === 1 && q_data === eq_d[0], "R5 stalled head", 64'(q_data), 64'(eq_d[0]));
    @(negedge clk); #1;
    chk(q_data === eq_d[0], "R5 stalled head stable", 64'(q_data), 64'(eq_d[0]));
    send(1, 2, 16'h5900, 0, 0); chk_ovf("R6 drop-new report");
    drain("R6 drop-new drain");
    ack_pulse(); chk_ovf("R9 ack clears flag only");

    // drop-old
    ovf_mode = 2'd1;
    for (int m = 0; m < DEPTH + 1; m++) send(1, 3, 16'h6000 + 16'(m * 16), 0, 0);
    chk_ovf("R7 drop-old report");
    drain("R7 drop-old drain");
    ack_pulse();

    // freeze
    ovf_mode = 2'd2;
    for (int m = 0; m < DEPTH + 1; m++) send(1, 1, 16'h7000 + 16'(m * 16), 0, 0);
    chk_ovf("R8 freeze report");
    drain("R8 pops while frozen");
    send(1, 2, 16'h7800, 0, 0);
    chk(q_valid === 0, "R8 frozen rejects into empty ring", 64'(q_valid), 64'd0);
    chk_ovf("R8 frozen rejection counted");
    ack_pulse();
    send(1, 2, 16'h7a00, 0, 0);
    chk(q_valid === 1, "R8 accepted after ack", 64'(q_valid), 64'd1);
    drain("R8 drain after ack");

    // overflow together with ack
    ovf_mode = 2'd0;
    for (int m = 0; m < DEPTH; m++) send(1, 1, 16'h8000 + 16'(m), 0, 0);
    send(1, 1, 16'h8100, 0, 1); chk_ovf("R9 overflow beats ack");
    drain("R6 drain");

    // tag rollover
    while (cyc[TW-1:0] != 8'd254) @(negedge clk);
    send(0, 1, 16'h9000, 0, 0); chk_per("R10 tag at rollover");
    chk(pt === 8'hff, "R10 tag value", 64'(pt), 64'hff);
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule